// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Controller

This block is the register front end of a peripheral. Through a 32-bit memory-mapped bus it lets software place the peripheral in soft reset and control the peripheral's clock gate. It also switches individual receiver and transmitter power-down lines and brings up a clock source. The clock source's lock time is modelled with a cycle counter.

The address space is split into 16-byte slots, one per register. In each slot, offset 0x0 is a plain read/write view of the register. Offset 0x4 sets every bit written as 1. Offset 0x8 clears every bit written as 1. Software can therefore change single bits without a read-modify-write.

When software requests soft reset, the controller gates the peripheral clock after a fixed internal delay. Software must see the gate status read back as 1 before it releases the reset. It then clears the gate request and polls until the status shows the clock running again.

Top module: `rstgate_ctl`

## Requirements
- R1: Each register slot is 16 bytes, with the slot index in address bits [5:4] and the access kind in bits [3:2]. Kind 0 writes the register, kind 1 ORs the written 1 bits in, and kind 2 clears the written 1 bits. Bits written as 0 at kind 1 or kind 2 keep their value. Writes with kind 3 are ignored, and reads of any kind return the register value.
- R2: In the control register (slot 0), bit 0 is the soft-reset request. Output `blk_rst` follows this bit.
- R3: While the soft-reset bit is 1, hardware holds the gate request (control bit 1) at 1. Control bit 1 reads the actual gate state. The gate state becomes 1 exactly GATE_DLY cycles after the write that set soft reset, so the first GATE_DLY polls read 0.
- R4: After soft reset is released, the gate state stays 1 until software clears the gate request. The gate state then reads 0 exactly GATE_DLY cycles after that write. `blk_clk_en` is the inverse of the gate state.
- R5: Slot 1 holds PWD_W power-down bits, all 1 after reset, and drives `pwr_down`.
- R6: While soft reset is 1, slots 1 and 2 are held at their reset values and writes to them have no effect.
- R7: In slot 2, bit 0 is clock-source power, bit 1 is the locked flag and bit 2 is the clock enable. Read-only bit 3 (`pll_lock`) becomes 1 exactly LOCK_CYC cycles after power is set. It returns to 0 one cycle after power is cleared.
- R8: `usb_clk_en` becomes 1 one cycle after slot 2 bits 0, 1 and 2 are all 1, and it is 0 otherwise.
- R9: Slot 3 is read-only and returns {VER_MAJOR, VER_MINOR} in bits [15:0]. Writes to it are ignored.
- R10: After reset, the control register is 0, the power-down bits are all 1, slot 2 is 0, `blk_clk_en` is 1 and `bus_rdata` is 0.
- R11: `bus_rdata` is registered. It updates in the cycle after a read request and holds its value through non-read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| blk_rst | output | 1 | Soft reset to the peripheral |
| blk_clk_en | output | 1 | Peripheral clock enable (1 = running) |
| pwr_down | output | PWD_W | Power-down lines |
| pll_on | output | 1 | Clock-source power |
| pll_lock | output | 1 | Modelled lock status |
| usb_clk_en | output | 1 | Enable for the generated clock |

## Verification
The hardest state to reach is the gate-status edge. It must be polled back-to-back in the exact cycles around GATE_DLY after the soft-reset write, and again after the gate-request clear. The bench therefore issues one read per cycle straight after each write, and it expects GATE_DLY zero reads followed by a one, or the reverse. A second awkward point is writing the power-down register while soft reset is held. The bench does this between the gate polls and the release, then reads the register back through the bus.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;
  typedef enum logic [1:0] {
    ACC_BASE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  localparam int SLOT_CTRL = 0;
  localparam int SLOT_PWD  = 1;
  localparam int SLOT_PLL  = 2;
  localparam int SLOT_VER  = 3;

  localparam int CTRL_HOLD = 0;
  localparam int CTRL_GATE = 1;

  localparam int PLL_PWR  = 0;
  localparam int PLL_LKD  = 1;
  localparam int PLL_EN   = 2;
  localparam int PLL_STAT = 3;
endpackage

// File: rtl/rstgate_alias_reg.sv
module rstgate_alias_reg
  import rstgate_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_hold,
  input  logic         wr,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = !wr                ? q[i] :
                    (acc == ACC_BASE)  ? wdata[i] :
                    (acc == ACC_SET)   ? (q[i] | wdata[i]) :
                    (acc == ACC_CLR)   ? (q[i] & ~wdata[i]) :
                                         q[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_hold) q <= RST;
    else                 q <= nxt | hw_set;
  end

  // R1: set alias raises every written 1
  p_set_hits_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && acc == ACC_SET && !clr_hold) |=> ((q & $past(wdata)) == $past(wdata)));
  // R1: clear alias drops written 1s not forced by hardware
  p_clr_hits_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && acc == ACC_CLR && !clr_hold) |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));
  // R1: zero bits at alias kinds stay unchanged
  p_alias_keeps_r1: assert property (@(posedge clk) disable iff (rst)
    (wr && acc != ACC_BASE && !clr_hold) |=>
      ((q & ~$past(wdata) & ~$past(hw_set)) == ($past(q) & ~$past(wdata) & ~$past(hw_set))));
endmodule

// File: rtl/rstgate_gate_hs.sv
module rstgate_gate_hs #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic target,
  output logic gate
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (target != gate) begin
      if (cnt == CW'(DLY - 1)) begin
        gate <= target;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R3: the gate state only ever moves toward the requested value
  p_gate_toward_target_r3: assert property (@(posedge clk) disable iff (rst)
    (gate != $past(gate)) |-> (gate == $past(target)));
  // R4: no counting while gate already matches
  p_idle_no_count_r4: assert property (@(posedge clk) disable iff (rst)
    (target == gate) |=> (cnt == '0));
endmodule

// File: rtl/rstgate_lock_timer.sv
module rstgate_lock_timer #(
  parameter int CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic lock
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      lock <= 1'b0;
    end else if (!lock) begin
      if (cnt == CW'(CYC - 1)) lock <= 1'b1;
      else                     cnt  <= cnt + 1'b1;
    end
  end

  // R7: lock only follows a powered cycle
  p_lock_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
    lock |-> $past(run));
  // R7: lock rises only once the full count has elapsed
  p_lock_full_count_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (cnt == CW'(CYC - 1)));
endmodule

// File: rtl/rstgate_ctl.sv
module rstgate_ctl
  import rstgate_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int PWD_W     = 7,
  parameter int GATE_DLY  = 4,
  parameter int LOCK_CYC  = 1250,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              blk_rst,
  output logic              blk_clk_en,
  output logic [PWD_W-1:0]  pwr_down,
  output logic              pll_on,
  output logic              pll_lock,
  output logic              usb_clk_en
);
  localparam int SLOT_LSB = 4;
  localparam int SLOT_W   = ADDR_W - SLOT_LSB;
  localparam int PLL_W    = 3;

  logic [SLOT_W-1:0] slot;
  acc_e              acc;
  logic              wr;
  logic              rd;
  logic [1:0]        ctrl_q;
  logic [PWD_W-1:0]  pwd_q;
  logic [PLL_W-1:0]  pll_q;
  logic              gate_q;
  logic              hold;
  logic              lock_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_bits;

  assign slot = bus_addr[ADDR_W-1:SLOT_LSB];
  assign acc  = acc_e'(bus_addr[3:2]);
  assign wr   = bus_en && bus_we;
  assign rd   = bus_en && !bus_we;
  assign hold = ctrl_q[CTRL_HOLD];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PWD_W]};

  rstgate_alias_reg #(.W(2), .RST(2'b00)) u_ctrl (
    .clk(clk), .rst(rst), .clr_hold(1'b0),
    .wr(wr && slot == SLOT_W'(SLOT_CTRL)), .acc(acc),
    .wdata(bus_wdata[1:0]), .hw_set({hold, 1'b0}), .q(ctrl_q)
  );

  rstgate_alias_reg #(.W(PWD_W), .RST({PWD_W{1'b1}})) u_pwd (
    .clk(clk), .rst(rst), .clr_hold(hold),
    .wr(wr && slot == SLOT_W'(SLOT_PWD)), .acc(acc),
    .wdata(bus_wdata[PWD_W-1:0]), .hw_set('0), .q(pwd_q)
  );

  rstgate_alias_reg #(.W(PLL_W), .RST('0)) u_pll (
    .clk(clk), .rst(rst), .clr_hold(hold),
    .wr(wr && slot == SLOT_W'(SLOT_PLL)), .acc(acc),
    .wdata(bus_wdata[PLL_W-1:0]), .hw_set('0), .q(pll_q)
  );

  rstgate_gate_hs #(.DLY(GATE_DLY)) u_hs (
    .clk(clk), .rst(rst), .target(hold | ctrl_q[CTRL_GATE]), .gate(gate_q)
  );

  rstgate_lock_timer #(.CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .run(pll_q[PLL_PWR]), .lock(lock_q)
  );

  always_comb begin
    rd_mux = '0;
    case (slot)
      SLOT_W'(SLOT_CTRL): begin
        rd_mux[CTRL_HOLD] = hold;
        rd_mux[CTRL_GATE] = gate_q;
      end
      SLOT_W'(SLOT_PWD): rd_mux[PWD_W-1:0] = pwd_q;
      SLOT_W'(SLOT_PLL): begin
        rd_mux[PLL_W-1:0] = pll_q;
        rd_mux[PLL_STAT]  = lock_q;
      end
      SLOT_W'(SLOT_VER): rd_mux[15:0] = {VER_MAJOR, VER_MINOR};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      en_q    <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      en_q <= &pll_q;
    end
  end

  assign bus_rdata  = rdata_q;
  assign blk_rst    = hold;
  assign blk_clk_en = ~gate_q;
  assign pwr_down   = pwd_q;
  assign pll_on     = pll_q[PLL_PWR];
  assign pll_lock   = lock_q;
  assign usb_clk_en = en_q;

  // R3: once gated under soft reset, stays gated while reset is held
  p_hold_keeps_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (hold && !blk_clk_en) |=> !blk_clk_en);
  // R6: soft reset returns the other registers to reset values
  p_hold_resets_regs_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (pwr_down == {PWD_W{1'b1}} && !pll_on));
  // R8: clock enable requires power in the prior cycle
  p_clk_en_needs_pwr_r8: assert property (@(posedge clk) disable iff (rst)
    usb_clk_en |-> $past(pll_on));
  // R11: read data changes only after a read request
  p_rdata_on_read_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata != $past(bus_rdata)) |-> $past(rd));
endmodule

// File: tb/rstgate_ctl_test.sv
`timescale 1ns/1ps
module rstgate_ctl_test;
  localparam int GD  = 4;
  localparam int LC  = 20;
  localparam logic [7:0] MAJ = 8'h03;
  localparam logic [7:0] MIN = 8'h07;
  localparam int NV  = 16;

  // row: {is_write, addr[5:0], wdata[31:0], expected read[31:0]}
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h10, 32'h55,   32'h0},     // R5 base write
    {1'b0, 6'h10, 32'h0,    32'h55},    // R1 R5
    {1'b1, 6'h14, 32'h0A,   32'h0},     // R1 set alias
    {1'b0, 6'h10, 32'h0,    32'h5F},
    {1'b1, 6'h18, 32'h41,   32'h0},     // R1 clear alias
    {1'b0, 6'h10, 32'h0,    32'h1E},
    {1'b1, 6'h1C, 32'h7F,   32'h0},     // R1 reserved kind ignored
    {1'b0, 6'h1C, 32'h0,    32'h1E},
    {1'b0, 6'h30, 32'h0,    {16'h0, MAJ, MIN}}, // R9
    {1'b1, 6'h30, 32'hFFFF, 32'h0},
    {1'b0, 6'h30, 32'h0,    {16'h0, MAJ, MIN}}, // R9 write ignored
    {1'b1, 6'h24, 32'h1,    32'h0},     // R7 power on
    {1'b0, 6'h20, 32'h0,    32'h1},
    {1'b1, 6'h28, 32'h1,    32'h0},
    {1'b0, 6'h20, 32'h0,    32'h0},
    {1'b0, 6'h00, 32'h0,    32'h0}      // R2 idle control
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        blk_rst, blk_clk_en, pll_on, pll_lock, usb_clk_en;
  logic [6:0]  pwr_down;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rstgate_ctl #(.GATE_DLY(GD), .LOCK_CYC(LC), .VER_MAJOR(MAJ), .VER_MINOR(MIN)) uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_rst(blk_rst),
    .blk_clk_en(blk_clk_en), .pwr_down(pwr_down), .pll_on(pll_on),
    .pll_lock(pll_lock), .usb_clk_en(usb_clk_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R10 reset state
    chk("R10 rdata", bus_rdata, 32'h0);
    chk("R10 clk_en", {31'h0, blk_clk_en}, 32'h1);
    chk("R10 pwr_down", {25'h0, pwr_down}, 32'h7F);
    chk("R10 pll/lock/en", {29'h0, pll_on, pll_lock, usb_clk_en}, 32'h0);
    rd(6'h00, d); chk("R10 ctrl", d, 32'h0);
    rd(6'h20, d); chk("R10 pll reg", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][69:64], d);
        chk($sformatf("table R1/R5/R7/R9 row %0d", i), d, VEC[i][31:0]);
      end
    end

    // R11 rdata holds across a write
    rd(6'h30, d);
    wr(6'h10, 32'h0);
    chk("R11 rdata hold", bus_rdata, {16'h0, MAJ, MIN});
    chk("R5 pwr_down port", {25'h0, pwr_down}, 32'h0);

    // soft reset sequence
    wr(6'h24, 32'h1);
    wr(6'h04, 32'h1);
    chk("R2 blk_rst", {31'h0, blk_rst}, 32'h1);
    for (int i = 1; i <= GD + 1; i++) begin
      rd(6'h00, d);
      chk($sformatf("R3 gate poll %0d", i), d, (i > GD) ? 32'h3 : 32'h1);
    end
    chk("R4 clk gated", {31'h0, blk_clk_en}, 32'h0);
    rd(6'h10, d); chk("R6 pwd held", d, 32'h7F);
    rd(6'h20, d); chk("R6 pll held", d, 32'h0);
    wr(6'h18, 32'h7F);
    rd(6'h10, d); chk("R6 write ignored", d, 32'h7F);

    wr(6'h08, 32'h1);
    rd(6'h00, d); chk("R4 gate stays", d, 32'h2);
    chk("R2 blk_rst low", {31'h0, blk_rst}, 32'h0);
    wr(6'h08, 32'h2);
    for (int i = 1; i <= GD + 1; i++) begin
      rd(6'h00, d);
      chk($sformatf("R4 ungate poll %0d", i), d, (i <= GD) ? 32'h2 : 32'h0);
    end
    chk("R4 clk running", {31'h0, blk_clk_en}, 32'h1);
    wr(6'h18, 32'h7F);
    chk("R5 clear after release", {25'h0, pwr_down}, 32'h0);

    // lock timing
    wr(6'h24, 32'h1);
    for (int k = 1; k <= LC; k++) begin
      tick();
      chk($sformatf("R7 lock cycle %0d", k), {31'h0, pll_lock}, (k == LC) ? 32'h1 : 32'h0);
    end
    rd(6'h20, d); chk("R7 status bit", d, 32'h9);
    wr(6'h24, 32'h2);
    chk("R8 not all bits", {31'h0, usb_clk_en}, 32'h0);
    wr(6'h24, 32'h4);
    chk("R8 one cycle late", {31'h0, usb_clk_en}, 32'h0);
    tick();
    chk("R8 enabled", {31'h0, usb_clk_en}, 32'h1);
    wr(6'h28, 32'h1);
    tick();
    chk("R7 lock dropped", {31'h0, pll_lock}, 32'h0);
    chk("R8 disabled", {31'h0, usb_clk_en}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule